// File: doc/BRIEF.md
# Iteration-Indexed Fabric Operand and Result Queue

This block sits between a processor pipeline and a spatial compute fabric. It holds two banks of slots. The send bank takes operands from the pipeline and streams them to the fabric. The receive bank takes results from the fabric and hands them back to the pipeline.

Every pipeline request carries an iteration number, and the slot it uses is that number modulo the bank depth. Requests may therefore arrive in any order and still meet the right fabric iteration. The fabric side moves strictly in increasing iteration order over a valid/ready handshake.

Slots are not released by the transfer itself. A slot is owned by the instruction block whose request reserved it, and a commit of that block releases it. A request that finds its slot still owned stalls until the slot is released. An abort (flush) of a block frees the operands that block sent without passing them to the fabric. The flush also drops the block's claims on results, but the results stay in place so that a replayed receive finds them again.

Top module: `fabric_iter_queue`

## Requirements
- R1: After reset both banks are empty. `fin_valid` is 0, `fout_ready` is 1, and any receive request sees `rcv_stall` = 1.
- R2: The fabric sees operands in increasing iteration order, starting at iteration 0, whatever order the sends came in. The pointer advances by one on each cycle with `fin_valid` and `fin_ready` both high. While `fin_valid` is high and `fin_ready` is low, the offered data holds steady unless a flush arrives.
- R3: `fin_valid` is high only when the slot at (fabric pointer mod DEPTH) holds an undelivered operand tagged with exactly the pointer's iteration. `fin_iter` shows that iteration and `fin_data` shows its data. A send for a later iteration leaves `fin_valid` low.
- R4: A send to slot (`snd_iter` mod DEPTH) is accepted (`snd_stall` = 0) only if that slot is free. If the slot still holds another iteration, `snd_stall` is 1 and nothing is written.
- R5: A send slot becomes free in the cycle after it has been both delivered to the fabric and committed by its block, whichever of the two comes last. A delivered operand that is not yet committed keeps its slot.
- R6: A flush of block B frees every send slot of B that is not yet committed. This includes undelivered slots, whose data never reaches the fabric. A later send for the same iteration writes fresh data, and that fresh data is what the fabric gets.
- R7: The fabric writes results in increasing iteration order, starting at iteration 0, into slot (pointer mod DEPTH). `fout_ready` is 1 only while that slot is empty, so after DEPTH unreleased results `fout_ready` is 0.
- R8: A receive is served (`rcv_stall` = 0, with `rcv_data` valid in the same cycle) only when its slot holds an unclaimed result tagged with exactly `rcv_iter`. It stalls if the result has not arrived, if the slot holds another iteration, or if the result is already claimed. A served receive claims the slot for `rcv_blk`.
- R9: A commit of block B empties every result slot claimed by B, and the fabric may write there again from the next cycle.
- R10: A flush of block B drops B's claims on results but keeps the results. A replayed receive for the same iteration returns the same data.
- R11: A commit or flush that names a block releases no slot owned by a different block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_req | input | 1 | Pipeline send request |
| snd_iter | input | ITER_W | Iteration number of the send |
| snd_blk | input | BLK_W | Block tag owning the send |
| snd_data | input | DATA_W | Operand value |
| snd_stall | output | 1 | Send not accepted this cycle |
| fin_valid | output | 1 | Operand offered to the fabric |
| fin_ready | input | 1 | Fabric takes the offered operand |
| fin_data | output | DATA_W | Offered operand |
| fin_iter | output | ITER_W | Iteration of the offered operand |
| fout_valid | input | 1 | Fabric presents a result |
| fout_ready | output | 1 | Result slot free for the fabric |
| fout_data | input | DATA_W | Result value from the fabric |
| rcv_req | input | 1 | Pipeline receive request |
| rcv_iter | input | ITER_W | Iteration number of the receive |
| rcv_blk | input | BLK_W | Block tag owning the receive |
| rcv_stall | output | 1 | Receive not served this cycle |
| rcv_data | output | DATA_W | Result returned to the receive |
| cmt_valid | input | 1 | Block commit strobe |
| cmt_blk | input | BLK_W | Committed block tag |
| flush_valid | input | 1 | Block abort strobe |
| flush_blk | input | BLK_W | Aborted block tag |

## Verification
The assertions assume that the pipeline keeps every issued iteration within DEPTH of the fabric pointer for its bank. They also assume that no block is flushed after one of its operands has already reached the fabric, and that each block tag names one live block at a time.

The stimulus keeps to these rules. Each bank uses at most DEPTH iterations ahead of its pointer. The send-side flush is issued while `fin_ready` is held low. The send blocks and the receive blocks use disjoint tag values, so commits and flushes aimed at one bank cannot touch the other.

// File: rtl/fiq_pkg.sv
package fiq_pkg;

   typedef enum logic [1:0] {
      S_FREE,
      S_PEND,
      S_PEND_CMT,
      S_SENT
   } snd_slot_e;

   typedef enum logic [1:0] {
      R_EMPTY,
      R_READY,
      R_CLAIMED
   } rcv_slot_e;

   // operand still waiting for the fabric
   function automatic logic snd_has_data(snd_slot_e s);
      return (s == S_PEND) || (s == S_PEND_CMT);
   endfunction

   function automatic snd_slot_e snd_next(snd_slot_e cur, logic put, logic take,
                                           logic cmt, logic fl);
      snd_slot_e n;
      n = cur;
      case (cur)
         S_FREE:     if (put) n = S_PEND;
         S_PEND: begin
            if (fl)               n = S_FREE;
            else if (take && cmt) n = S_FREE;
            else if (take)        n = S_SENT;
            else if (cmt)         n = S_PEND_CMT;
         end
         S_PEND_CMT: if (take) n = S_FREE;
         S_SENT:     if (cmt || fl) n = S_FREE;
         default:    n = S_FREE;
      endcase
      return n;
   endfunction

   function automatic rcv_slot_e rcv_next(rcv_slot_e cur, logic put, logic claim,
                                           logic cmt, logic fl);
      rcv_slot_e n;
      n = cur;
      case (cur)
         R_EMPTY:   if (put) n = R_READY;
         R_READY:   if (claim) n = R_CLAIMED;
         R_CLAIMED: begin
            if (cmt)     n = R_EMPTY;
            else if (fl) n = R_READY;
         end
         default:   n = R_EMPTY;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/fiq_iter_ptr.sv
module fiq_iter_ptr #(
   parameter int ITER_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   output logic [ITER_W-1:0] iter_o
);

   logic [ITER_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (adv_i) cnt_q <= cnt_q + 1'b1;
   end

   assign iter_o = cnt_q;

endmodule

// File: rtl/fiq_send_bank.sv
module fiq_send_bank
   import fiq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ITER_W = 6,
   parameter int BLK_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ITER_W-1:0] iter_i,
   input  logic [BLK_W-1:0]  blk_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              stall_o,
   input  logic [ITER_W-1:0] head_i,
   input  logic              take_i,
   output logic              fvalid_o,
   output logic [DATA_W-1:0] fdata_o,
   input  logic              cmt_valid_i,
   input  logic [BLK_W-1:0]  cmt_blk_i,
   input  logic              fl_valid_i,
   input  logic [BLK_W-1:0]  fl_blk_i
);

   localparam int IDX_W = $clog2(DEPTH);

   snd_slot_e         st_q  [DEPTH];
   snd_slot_e         st_d  [DEPTH];
   logic [ITER_W-1:0] it_q  [DEPTH];
   logic [BLK_W-1:0]  blk_q [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   logic [DEPTH-1:0]  put_v;

   logic [IDX_W-1:0]  req_idx;
   logic [IDX_W-1:0]  head_idx;
   logic              busy;

   assign req_idx  = iter_i[IDX_W-1:0];
   assign head_idx = head_i[IDX_W-1:0];
   assign busy     = (st_q[req_idx] != S_FREE);
   assign stall_o  = req_i && busy;

   assign fvalid_o = snd_has_data(st_q[head_idx]) && (it_q[head_idx] == head_i);
   assign fdata_o  = dat_q[head_idx];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic put, take, cmt_hit, fl_hit;
      assign put     = req_i && !busy && (req_idx == IDX_W'(s));
      assign take    = take_i && (head_idx == IDX_W'(s));
      assign cmt_hit = cmt_valid_i && (cmt_blk_i == blk_q[s]);
      assign fl_hit  = fl_valid_i && (fl_blk_i == blk_q[s]);
      assign st_d[s] = snd_next(st_q[s], put, take, cmt_hit, fl_hit);
      assign put_v[s] = put;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) st_q[k] <= S_FREE;
      end else begin
         for (int k = 0; k < DEPTH; k++) st_q[k] <= st_d[k];
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < DEPTH; k++) begin
         if (put_v[k]) begin
            it_q[k]  <= iter_i;
            blk_q[k] <= blk_i;
            dat_q[k] <= data_i;
         end
      end
   end

endmodule

// File: rtl/fiq_recv_bank.sv
module fiq_recv_bank
   import fiq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ITER_W = 6,
   parameter int BLK_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ITER_W-1:0] head_i,
   input  logic              fvalid_i,
   input  logic [DATA_W-1:0] fdata_i,
   output logic              fready_o,
   input  logic              req_i,
   input  logic [ITER_W-1:0] iter_i,
   input  logic [BLK_W-1:0]  blk_i,
   output logic              stall_o,
   output logic [DATA_W-1:0] data_o,
   input  logic              cmt_valid_i,
   input  logic [BLK_W-1:0]  cmt_blk_i,
   input  logic              fl_valid_i,
   input  logic [BLK_W-1:0]  fl_blk_i
);

   localparam int IDX_W = $clog2(DEPTH);

   rcv_slot_e         st_q  [DEPTH];
   rcv_slot_e         st_d  [DEPTH];
   logic [ITER_W-1:0] it_q  [DEPTH];
   logic [BLK_W-1:0]  blk_q [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   logic [DEPTH-1:0]  put_v;
   logic [DEPTH-1:0]  claim_v;

   logic [IDX_W-1:0]  head_idx;
   logic [IDX_W-1:0]  req_idx;
   logic              hit;
   logic              wr;

   assign head_idx = head_i[IDX_W-1:0];
   assign req_idx  = iter_i[IDX_W-1:0];
   assign fready_o = (st_q[head_idx] == R_EMPTY);
   assign wr       = fvalid_i && fready_o;
   assign hit      = (st_q[req_idx] == R_READY) && (it_q[req_idx] == iter_i);
   assign stall_o  = req_i && !hit;
   assign data_o   = dat_q[req_idx];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic put, claim, cmt_hit, fl_hit;
      assign put     = wr && (head_idx == IDX_W'(s));
      assign claim   = req_i && hit && (req_idx == IDX_W'(s));
      assign cmt_hit = cmt_valid_i && (cmt_blk_i == blk_q[s]);
      assign fl_hit  = fl_valid_i && (fl_blk_i == blk_q[s]);
      assign st_d[s] = rcv_next(st_q[s], put, claim, cmt_hit, fl_hit);
      assign put_v[s]   = put;
      assign claim_v[s] = claim;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) st_q[k] <= R_EMPTY;
      end else begin
         for (int k = 0; k < DEPTH; k++) st_q[k] <= st_d[k];
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < DEPTH; k++) begin
         if (put_v[k]) begin
            it_q[k]  <= head_i;
            dat_q[k] <= fdata_i;
         end
         if (claim_v[k]) blk_q[k] <= blk_i;
      end
   end

endmodule

// File: rtl/fabric_iter_queue.sv
module fabric_iter_queue #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int ITER_W = 6,
   parameter int BLK_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snd_req,
   input  logic [ITER_W-1:0] snd_iter,
   input  logic [BLK_W-1:0]  snd_blk,
   input  logic [DATA_W-1:0] snd_data,
   output logic              snd_stall,
   output logic              fin_valid,
   input  logic              fin_ready,
   output logic [DATA_W-1:0] fin_data,
   output logic [ITER_W-1:0] fin_iter,
   input  logic              fout_valid,
   output logic              fout_ready,
   input  logic [DATA_W-1:0] fout_data,
   input  logic              rcv_req,
   input  logic [ITER_W-1:0] rcv_iter,
   input  logic [BLK_W-1:0]  rcv_blk,
   output logic              rcv_stall,
   output logic [DATA_W-1:0] rcv_data,
   input  logic              cmt_valid,
   input  logic [BLK_W-1:0]  cmt_blk,
   input  logic              flush_valid,
   input  logic [BLK_W-1:0]  flush_blk
);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ITER_W <= $clog2(DEPTH)) begin : g_bad_iter
      $error("ITER_W must exceed the slot index width");
   end
   if ((DATA_W < 1) || (BLK_W < 1)) begin : g_bad_width
      $error("DATA_W and BLK_W must be positive");
   end

   logic              fin_take;
   logic              fout_take;
   logic [ITER_W-1:0] out_head;

   assign fin_take  = fin_valid && fin_ready;
   assign fout_take = fout_valid && fout_ready;

   fiq_iter_ptr #(.ITER_W(ITER_W)) u_in_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (fin_take),
      .iter_o (fin_iter)
   );

   fiq_iter_ptr #(.ITER_W(ITER_W)) u_out_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (fout_take),
      .iter_o (out_head)
   );

   fiq_send_bank #(
      .DEPTH(DEPTH), .ITER_W(ITER_W), .BLK_W(BLK_W), .DATA_W(DATA_W)
   ) u_send (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (snd_req),
      .iter_i      (snd_iter),
      .blk_i       (snd_blk),
      .data_i      (snd_data),
      .stall_o     (snd_stall),
      .head_i      (fin_iter),
      .take_i      (fin_take),
      .fvalid_o    (fin_valid),
      .fdata_o     (fin_data),
      .cmt_valid_i (cmt_valid),
      .cmt_blk_i   (cmt_blk),
      .fl_valid_i  (flush_valid),
      .fl_blk_i    (flush_blk)
   );

   fiq_recv_bank #(
      .DEPTH(DEPTH), .ITER_W(ITER_W), .BLK_W(BLK_W), .DATA_W(DATA_W)
   ) u_recv (
      .clk         (clk),
      .rst_n       (rst_n),
      .head_i      (out_head),
      .fvalid_i    (fout_valid),
      .fdata_i     (fout_data),
      .fready_o    (fout_ready),
      .req_i       (rcv_req),
      .iter_i      (rcv_iter),
      .blk_i       (rcv_blk),
      .stall_o     (rcv_stall),
      .data_o      (rcv_data),
      .cmt_valid_i (cmt_valid),
      .cmt_blk_i   (cmt_blk),
      .fl_valid_i  (flush_valid),
      .fl_blk_i    (flush_blk)
   );

endmodule

// File: rtl/fabric_iter_queue_chk.sv
module fabric_iter_queue_chk #(
   parameter int DATA_W = 32,
   parameter int ITER_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snd_req,
   input logic [ITER_W-1:0] snd_iter,
   input logic              snd_stall,
   input logic              fin_valid,
   input logic              fin_ready,
   input logic [DATA_W-1:0] fin_data,
   input logic [ITER_W-1:0] fin_iter,
   input logic              rcv_req,
   input logic [ITER_W-1:0] rcv_iter,
   input logic              rcv_stall,
   input logic              flush_valid
);

   AST_FIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_valid && fin_ready) |=> (fin_iter == ITER_W'($past(fin_iter) + 1'b1))); // R2

   AST_FIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_valid && !fin_ready && !flush_valid) |=> (fin_valid && $stable(fin_data) && $stable(fin_iter))); // R2

   AST_FIN_NEEDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fin_valid) |-> $past(snd_req && !snd_stall)); // R3

   AST_SND_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_req && !snd_stall) |=> !(snd_req && (snd_iter == $past(snd_iter)) && !snd_stall)); // R4

   AST_RCV_CLAIM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_req && !rcv_stall) |=> !(rcv_req && (rcv_iter == $past(rcv_iter)) && !rcv_stall)); // R8

endmodule

bind fabric_iter_queue fabric_iter_queue_chk #(.DATA_W(DATA_W), .ITER_W(ITER_W)) u_chk (.*);

// File: tb/fabric_iter_queue_tb.sv
module fabric_iter_queue_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int IW = 6;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snd_req = 1'b0;
   logic [IW-1:0] snd_iter = '0;
   logic [BW-1:0] snd_blk = '0;
   logic [DW-1:0] snd_data = '0;
   logic          snd_stall;
   logic          fin_valid;
   logic          fin_ready = 1'b0;
   logic [DW-1:0] fin_data;
   logic [IW-1:0] fin_iter;
   logic          fout_valid = 1'b0;
   logic          fout_ready;
   logic [DW-1:0] fout_data = '0;
   logic          rcv_req = 1'b0;
   logic [IW-1:0] rcv_iter = '0;
   logic [BW-1:0] rcv_blk = '0;
   logic          rcv_stall;
   logic [DW-1:0] rcv_data;
   logic          cmt_valid = 1'b0;
   logic [BW-1:0] cmt_blk = '0;
   logic          flush_valid = 1'b0;
   logic [BW-1:0] flush_blk = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [DW-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   fabric_iter_queue #(.DEPTH(8), .DATA_W(DW), .ITER_W(IW), .BLK_W(BW)) u_dut (.*);

   function automatic logic [DW-1:0] sd(input int i);
      return 32'h5000_0000 | i;
   endfunction

   function automatic logic [DW-1:0] fo(input int i);
      return 32'h7000_0000 | i;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
   endtask

   // scoreboard monitor: fabric-side operand stream
   initial begin : mon
      forever begin
         @(negedge clk);
         if (rst_n && fin_valid && fin_ready) begin
            if (exp_q.size() == 0) begin
               chk("R2 unexpected operand", 64'(fin_data), 64'hFFFF_FFFF_FFFF);
            end else begin
               chk("R2 operand order", 64'(fin_data), 64'(exp_q.pop_front()));
            end
         end
      end
   end

   task automatic do_send(input int it, input int bk, input logic [DW-1:0] d, output logic st);
      snd_req = 1'b1; snd_iter = IW'(it); snd_blk = BW'(bk); snd_data = d;
      @(negedge clk);
      st = snd_stall;
      @(posedge clk); #1;
      snd_req = 1'b0;
   endtask

   task automatic do_rcv(input int it, input int bk, output logic st, output logic [DW-1:0] d);
      rcv_req = 1'b1; rcv_iter = IW'(it); rcv_blk = BW'(bk);
      @(negedge clk);
      st = rcv_stall;
      d = rcv_data;
      @(posedge clk); #1;
      rcv_req = 1'b0;
   endtask

   task automatic do_push(input logic [DW-1:0] d, output logic rdy);
      fout_valid = 1'b1; fout_data = d;
      @(negedge clk);
      rdy = fout_ready;
      @(posedge clk); #1;
      fout_valid = 1'b0;
   endtask

   task automatic do_commit(input int bk);
      cmt_valid = 1'b1; cmt_blk = BW'(bk);
      @(posedge clk); #1;
      cmt_valid = 1'b0;
   endtask

   task automatic do_flush(input int bk);
      flush_valid = 1'b1; flush_blk = BW'(bk);
      @(posedge clk); #1;
      flush_valid = 1'b0;
   endtask

   task automatic drain();
      fin_ready = 1'b1;
      for (int n = 0; n < 40 && exp_q.size() != 0; n++) @(posedge clk);
      #1;
      fin_ready = 1'b0;
      chk("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin : main
      logic st;
      logic rdy;
      logic [DW-1:0] d;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 fin_valid after reset", 64'(fin_valid), 64'd0);
      chk("R1 fout_ready after reset", 64'(fout_ready), 64'd1);
      @(posedge clk); #1;
      do_rcv(0, 0, st, d);
      chk("R1 receive stalls when empty", 64'(st), 64'd1);

      // out-of-order sends, in-order stream
      do_send(2, 1, sd(2), st);
      chk("R4 send to free slot", 64'(st), 64'd0);
      @(negedge clk);
      chk("R3 later iteration not offered", 64'(fin_valid), 64'd0);
      @(posedge clk); #1;
      do_send(0, 1, sd(0), st);
      @(negedge clk);
      chk("R3 head offered", 64'(fin_valid), 64'd1);
      chk("R3 head iteration", 64'(fin_iter), 64'd0);
      chk("R3 head data", 64'(fin_data), 64'(sd(0)));
      @(posedge clk); #1;
      do_send(3, 1, sd(3), st);
      do_send(1, 1, sd(1), st);
      for (int i = 0; i < 4; i++) exp_q.push_back(sd(i));
      drain();
      @(negedge clk);
      chk("R3 nothing at iteration 4", 64'(fin_valid), 64'd0);
      chk("R2 pointer at 4", 64'(fin_iter), 64'd4);
      @(posedge clk); #1;

      // slot reuse needs commit
      do_send(8, 3, sd(8), st);
      chk("R4 occupied slot stalls", 64'(st), 64'd1);
      do_commit(2);
      do_send(8, 3, sd(8), st);
      chk("R11 other block commit keeps slot", 64'(st), 64'd1);
      do_commit(1);
      do_send(8, 3, sd(8), st);
      chk("R5 slot free after commit", 64'(st), 64'd0);
      do_send(4, 3, sd(4), st);
      do_send(5, 3, sd(5), st);
      @(negedge clk);
      chk("R2 iteration 4 offered", 64'(fin_valid), 64'd1);
      @(posedge clk); #1;

      // flush drops undelivered operands
      do_flush(3);
      @(negedge clk);
      chk("R6 flushed operand not offered", 64'(fin_valid), 64'd0);
      @(posedge clk); #1;
      do_send(8, 4, sd(8), st);
      chk("R6 flush freed slot", 64'(st), 64'd0);
      do_send(4, 4, 32'h6000_0004, st);
      @(negedge clk);
      chk("R6 replay data offered", 64'(fin_data), 64'h6000_0004);
      @(posedge clk); #1;
      exp_q.push_back(32'h6000_0004);
      drain();

      // result side
      for (int i = 0; i < 8; i++) begin
         do_push(fo(i), rdy);
         chk("R7 result slot free", 64'(rdy), 64'd1);
      end
      do_push(fo(8), rdy);
      chk("R7 full bank refuses", 64'(rdy), 64'd0);
      do_rcv(3, 5, st, d);
      chk("R8 receive served", 64'(st), 64'd0);
      chk("R8 receive data it3", 64'(d), 64'(fo(3)));
      do_rcv(1, 5, st, d);
      chk("R8 receive data it1", 64'(d), 64'(fo(1)));
      do_rcv(9, 5, st, d);
      chk("R8 wrong iteration stalls", 64'(st), 64'd1);
      do_rcv(3, 6, st, d);
      chk("R8 claimed result stalls", 64'(st), 64'd1);
      do_flush(5);
      do_rcv(3, 6, st, d);
      chk("R10 replay served", 64'(st), 64'd0);
      chk("R10 replay data", 64'(d), 64'(fo(3)));
      do_rcv(0, 6, st, d);
      chk("R8 receive data it0", 64'(d), 64'(fo(0)));
      do_commit(7);
      do_push(fo(8), rdy);
      chk("R11 other block commit keeps result slot", 64'(rdy), 64'd0);
      do_commit(6);
      do_push(fo(8), rdy);
      chk("R9 slot reopened by commit", 64'(rdy), 64'd1);
      do_rcv(8, 7, st, d);
      chk("R9 new result served", 64'(st), 64'd0);
      chk("R9 new result data", 64'(d), 64'(fo(8)));
      do_rcv(1, 7, st, d);
      chk("R10 flushed claim data kept", 64'(d), 64'(fo(1)));

      repeat (3) @(posedge clk);
      summary();
      $finish;
   end

endmodule